// File: doc/BRIEF.md
# Edge Timestamp Event Tagger

This block watches a set of pulse lines that are asynchronous to the system clock. Each line passes through a chain of synchronizer flops. Every change of level on a synchronized line becomes one record. A record holds the channel number, the new level (the edge direction) and the value of a free-running cycle counter. Records go into an on-chip queue. A slower consumer, such as a serial link, drains the queue through a first-word-fall-through valid/ready port.

Several lines may change in the same cycle. All of their records are written in that one cycle, in ascending channel order, and they share one timestamp. A record is never lost while the queue has room. When there is no room, each record that cannot be stored is counted in a saturating loss counter, and a sticky overflow flag is raised.

Top module: `edge_tagger`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rd_valid`, `overflow` and `lost_count` are all zero.
- R2: Each line passes through SYNC synchronizer flops. A level sampled at clock edge p is written to the queue at edge p+SYNC, so `rd_valid` can rise no earlier than after that edge.
- R3: The timestamp counter is TSW bits wide, is zero after reset, and advances by one each cycle, wrapping silently. A record written at the k-th rising edge after reset carries timestamp (k-1) mod 2^TSW.
- R4: Record layout: channel index in the top CHW bits, direction at bit TSW (1 = rising, 0 = falling), timestamp in bits TSW-1:0.
- R5: Edges detected in the same cycle on several channels are stored in ascending channel order with identical timestamps.
- R6: The head record appears on `rd_data` with `rd_valid` high whenever the queue is not empty. It is removed at an edge where `rd_valid` and `rd_ready` are both high, and it stays stable while `rd_ready` is low. Records leave in arrival order.
- R7: The room for a cycle's records is DEPTH minus the number of entries held at the start of that cycle. A slot freed by a read in the same cycle does not count. Records beyond the room are dropped, and the lowest channels are kept.
- R8: `overflow` goes high in the cycle after the first drop and stays high until reset.
- R9: `lost_count` increases by the number of records dropped in each cycle and saturates at 2^LOSTW-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | NCH | Raw asynchronous pulse lines |
| rd_ready | input | 1 | Consumer accepts the head record |
| rd_data | output | CHW+1+TSW | Head record {channel, direction, timestamp} |
| rd_valid | output | 1 | Queue holds at least one record |
| overflow | output | 1 | Sticky flag: a record was dropped |
| lost_count | output | LOSTW | Saturating count of dropped records |

## Verification
A level that the bench drives before edge p first becomes visible one edge after the SYNC-flop chain. The record is written at edge p+SYNC and carries timestamp p+SYNC-1. The overflow flag and the loss counter change at that same edge. A pop takes effect at the edge where valid and ready are both high. The bench drives its inputs on falling edges and counts rising edges itself. Its queue model applies each of these offsets at the rising edge. It compares all outputs at the following falling edge, and the directed checks wait exactly the computed number of falling edges before sampling.

// File: rtl/edge_tagger.sv
module edge_tagger #(
  parameter int NCH   = 2,
  parameter int TSW   = 32,
  parameter int DEPTH = 16,
  parameter int LOSTW = 16,
  parameter int SYNC  = 2,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int REC_W = CHW + 1 + TSW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   pulse_in,
  input  logic             rd_ready,
  output logic [REC_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             overflow,
  output logic [LOSTW-1:0] lost_count
);
  localparam int ADDRW = $clog2(DEPTH);
  localparam int CNTW  = ADDRW + 1;
  localparam int DW    = $clog2(NCH + 1);
  localparam int SUMW  = LOSTW + DW;

  logic [SYNC-1:0][NCH-1:0] sync_q;
  logic [NCH-1:0]           prev_q, samp, edge_v;
  logic [TSW-1:0]           ts_q;
  logic [REC_W-1:0]         mem [DEPTH];
  logic [ADDRW-1:0]         wr_ptr, rd_ptr;
  logic [CNTW-1:0]          count_q, room, n_acc;
  logic [DW-1:0]            drops;
  logic [NCH-1:0]           acc;
  logic [ADDRW-1:0]         waddr [NCH];
  logic [REC_W-1:0]         rec [NCH];
  logic [SUMW-1:0]          lost_sum;
  logic                     pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pulse_in;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign samp   = sync_q[SYNC-1];
  assign edge_v = samp ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) ts_q <= '0;
    else     ts_q <= ts_q + 1'b1;
  end

  assign room = CNTW'(DEPTH) - count_q;

  always_comb begin
    n_acc = '0;
    drops = '0;
    for (int c = 0; c < NCH; c++) begin
      rec[c]   = {CHW'(c), samp[c], ts_q};
      waddr[c] = wr_ptr + ADDRW'(n_acc);
      acc[c]   = 1'b0;
      if (edge_v[c]) begin
        if (n_acc < room) begin
          acc[c] = 1'b1;
          n_acc  = n_acc + 1'b1;
        end else begin
          drops = drops + 1'b1;
        end
      end
    end
  end

  assign rd_valid = (count_q != '0);
  assign rd_data  = mem[rd_ptr];
  assign pop      = rd_valid & rd_ready;

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++)
      if (acc[c]) mem[waddr[c]] <= rec[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      wr_ptr  <= wr_ptr + ADDRW'(n_acc);
      rd_ptr  <= rd_ptr + ADDRW'(pop);
      count_q <= count_q + n_acc - CNTW'(pop);
    end
  end

  assign lost_sum = {{DW{1'b0}}, lost_count} + SUMW'(drops);

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow   <= 1'b0;
      lost_count <= '0;
    end else begin
      if (drops != '0) overflow <= 1'b1;
      if (lost_sum[SUMW-1:LOSTW] != '0) lost_count <= '1;
      else                              lost_count <= lost_sum[LOSTW-1:0];
    end
  end
endmodule

// File: rtl/edge_tagger_chk.sv
module edge_tagger_chk #(
  parameter int REC_W = 34,
  parameter int TSW   = 32,
  parameter int LOSTW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [REC_W-1:0] rd_data,
  input logic             overflow,
  input logic [LOSTW-1:0] lost_count,
  input logic [TSW-1:0]   ts_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rd_valid && !overflow && lost_count == '0));

  // R3
  ts_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ts_q == TSW'($past(ts_q) + 1'b1));

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R9
  lost_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> lost_count >= $past(lost_count));

  // R9
  lost_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (lost_count != '0) |-> overflow);
endmodule

bind edge_tagger edge_tagger_chk #(.REC_W(REC_W), .TSW(TSW), .LOSTW(LOSTW)) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .overflow(overflow), .lost_count(lost_count), .ts_q(ts_q)
);

// File: tb/sim_edge_tagger.sv
module sim_edge_tagger;
  localparam int CLK_T = 10;
  localparam int NCH   = 3;
  localparam int TSW   = 8;
  localparam int DEPTH = 8;
  localparam int LOSTW = 4;
  localparam int SYNC  = 2;
  localparam int CHW   = 2;
  localparam int REC_W = CHW + 1 + TSW;
  localparam int LMAX  = (1 << LOSTW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] pulse_in = '0;
  logic rd_ready = 1'b0;
  logic [REC_W-1:0] rd_data;
  logic rd_valid, overflow;
  logic [LOSTW-1:0] lost_count;

  edge_tagger #(.NCH(NCH), .TSW(TSW), .DEPTH(DEPTH), .LOSTW(LOSTW), .SYNC(SYNC)) u0 (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .overflow(overflow), .lost_count(lost_count)
  );

  always #(CLK_T/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [REC_W-1:0] mq [$];
  logic [NCH-1:0]   hist [SYNC+1];
  int m_lost = 0;
  bit m_ovf = 0;
  int edges = 0;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_lost = 0;
      m_ovf  = 0;
      edges  = 0;
      for (int k = 0; k <= SYNC; k++) hist[k] = '0;
    end else begin
      int room;
      int took;
      room = DEPTH - mq.size();
      took = 0;
      if (mq.size() != 0 && rd_ready) void'(mq.pop_front());
      for (int c = 0; c < NCH; c++) begin
        if (hist[SYNC-1][c] != hist[SYNC][c]) begin
          if (took < room) begin
            mq.push_back({CHW'(c), hist[SYNC-1][c], TSW'(edges)});
            took++;
          end else begin
            m_ovf = 1;
            if (m_lost < LMAX) m_lost++;
          end
        end
      end
      edges++;
      for (int k = SYNC; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = pulse_in;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R6 valid", rd_valid, mq.size() != 0);
      if (mq.size() != 0) check("R6 head record", rd_data, mq[0]);
      check("R8 overflow", overflow, m_ovf);
      check("R9 lost", lost_count, m_lost);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pulse_in = '0;
    rd_ready = 1'b0;
    step(3);
    check("R1 valid in reset", rd_valid, 0);
    check("R1 overflow in reset", overflow, 0);
    check("R1 lost in reset", lost_count, 0);
    rst = 1'b0;
  endtask

  task automatic drain();
    rd_ready = 1'b1;
    step(DEPTH + 2);
    rd_ready = 1'b0;
  endtask

  initial begin
    int k;
    int t0;
    do_reset();
    step(1);
    check("R1 valid after reset", rd_valid, 0);

    // R2 R3 R4: single rising edge on channel 0
    step(4);
    k = edges;
    pulse_in[0] = 1'b1;
    step(SYNC);
    check("R2 not yet written", rd_valid, 0);
    step(1);
    check("R2 written", rd_valid, 1);
    check("R4 channel", rd_data[REC_W-1 -: CHW], 0);
    check("R4 rising dir", rd_data[TSW], 1);
    check("R3 timestamp", rd_data[TSW-1:0], (k + SYNC) % 256);
    drain();

    // R4 falling
    pulse_in[0] = 1'b0;
    step(SYNC + 1);
    check("R4 falling dir", rd_data[TSW], 0);
    drain();

    // R5 simultaneous edges
    pulse_in = '1;
    step(SYNC + 1);
    check("R5 first channel", rd_data[REC_W-1 -: CHW], 0);
    t0 = rd_data[TSW-1:0];
    rd_ready = 1'b1;
    step(1);
    check("R5 second channel", rd_data[REC_W-1 -: CHW], 1);
    check("R5 shared ts", rd_data[TSW-1:0], t0);
    step(1);
    check("R5 third channel", rd_data[REC_W-1 -: CHW], 2);
    check("R5 shared ts 2", rd_data[TSW-1:0], t0);
    step(1);
    check("R6 empty after reads", rd_valid, 0);
    rd_ready = 1'b0;

    // R7 full queue with a read in the same cycle
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      pulse_in[0] = ~pulse_in[0];
      step(1);
    end
    step(4);
    check("R7 full no loss", lost_count, 0);
    pulse_in[0] = ~pulse_in[0];
    step(SYNC);
    rd_ready = 1'b1;
    step(1);
    rd_ready = 1'b0;
    check("R7 read does not free slot", lost_count, 1);
    check("R8 overflow set", overflow, 1);

    // R9 saturation
    for (int i = 0; i < 10; i++) begin
      pulse_in = ~pulse_in;
      step(1);
    end
    step(4);
    check("R9 saturated", lost_count, LMAX);
    check("R8 still set", overflow, 1);
    drain();
    check("R8 sticky after drain", overflow, 1);

    // R3 wrap, then mixed traffic
    do_reset();
    step(300);
    k = edges;
    pulse_in[1] = 1'b1;
    step(SYNC + 1);
    check("R3 wrapped ts", rd_data[TSW-1:0], (k + SYNC) % 256);
    check("R4 channel 1", rd_data[REC_W-1 -: CHW], 1);
    drain();
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(2) == 0) pulse_in[c] = ~pulse_in[c];
      rd_ready = ($urandom_range(1) == 1);
      step(1);
    end
    drain();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule